// File: doc/BRIEF.md
# Sliding-Window Rank Order Selector

This block holds the most recent samples of a data stream in a list that is always in ascending order, and on every clock it presents one fixed order statistic of that window. The default window is 32 samples of 16 bits, and the default output is the 24th smallest value. This is the value an order-statistic CFAR detector scales into its threshold. Threshold scaling and the detection decision are left to the logic downstream.

Each accepted sample enters the list at its sorted position, and the oldest sample leaves the list in the same cycle. There is no full re-sort. Every stored entry is compared against the new sample in parallel, and each slot then keeps its own value or takes the value of a neighbour. The list starts empty after reset. Empty slots sit at the top of the list, so the window fills in sorted order. The rank output is reported valid only once the window is full.

Top module: `rank_select`

## Requirements
- R1: A synchronous, active-high reset empties the window and clears the fill count. `rank_valid` reads 0 on the first clock after reset.
- R2: Stored entries stay in ascending order at all times. Occupied slots form a contiguous run from slot 0, and empty slots sit above them.
- R3: While `rank_valid` is 1, `rank_out` equals the RANK-th smallest (1-based, default 24) of the last DEPTH accepted samples. It is updated on the clock edge that accepts a sample.
- R4: Once the window is full, each accepted sample removes exactly one entry: the one that was accepted DEPTH samples earlier.
- R5: `rank_valid` stays 0 for the first DEPTH-1 accepted samples after reset. It becomes 1 on the edge that accepts sample number DEPTH and stays 1 until the next reset.
- R6: A cycle with `in_valid` = 0 changes neither the stored window nor `rank_out` nor `rank_valid`.
- R7: Repeated equal values are kept as separate entries. A new value equal to stored ones goes above them, and retiring one copy leaves the other copies in place.
- R8: With SIGNED_CMP = 0, samples compare as unsigned numbers. With SIGNED_CMP = 1 they compare as two's-complement numbers, so 16'hFFF0 ranks below 16'h0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is offered on in_data this cycle |
| in_data | input | DW | New sample |
| rank_valid | output | 1 | Window full; rank_out is meaningful |
| rank_out | output | DW | Entry at position RANK of the ascending window |

## Verification
On every cycle, the assertions check the following: the list stays in order, occupied slots stay contiguous from slot 0, at most one slot expires per cycle, an idle cycle leaves every slot unchanged, a full flag implies a full window, and reset empties the list. The bench's scenarios are the only way to show that the selected value is actually the right order statistic of the right 32 samples. This includes whether the oldest copy of a duplicated value is the one that goes, and whether the output flips at the expected sample in a staged drop-out test. Signed and unsigned ordering are compared by running two instances on one stream.

// File: rtl/rank_pkg.sv
package rank_pkg;
  // Source a slot takes its next content from
  typedef enum logic [1:0] {
    MV_KEEP       = 2'd0,  // own entry
    MV_FROM_ABOVE = 2'd1,  // entry of slot i+1 (list closes over a removed entry)
    MV_FROM_BELOW = 2'd2,  // entry of slot i-1 (list opens for the new sample)
    MV_LOAD       = 2'd3   // the incoming sample
  } move_t;
endpackage

// File: rtl/rank_probe.sv
// Per-slot comparison against the incoming sample and expiry detection.
module rank_probe #(
  parameter int DW         = 16,
  parameter int DEPTH      = 32,
  parameter bit SIGNED_CMP = 1'b0,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          vld,
  input  logic [AW-1:0] age,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] sample,
  output logic          not_above,  // occupied and <= sample: stays below the new entry
  output logic          expiring    // oldest entry, leaves on the next accept
);
  localparam logic [AW-1:0] AGE_LAST = AW'(DEPTH - 1);

  logic le;

  generate
    if (SIGNED_CMP) begin : g_signed
      assign le = $signed(data) <= $signed(sample);
    end else begin : g_unsigned
      assign le = data <= sample;
    end
  endgenerate

  assign not_above = vld & le;
  assign expiring  = vld & (age == AGE_LAST);
endmodule

// File: rtl/rank_place.sv
// Finds where the new sample lands and which slot drops out.
module rank_place #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] not_above,
  input  logic [DEPTH-1:0] expiring,
  output logic [PW-1:0]    ins_pos,
  output logic [AW-1:0]    drop_pos,
  output logic             drop_any
);
  always_comb begin
    ins_pos  = '0;
    drop_pos = '0;
    drop_any = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      // entries that remain below the new sample once the expiring one is gone
      ins_pos = ins_pos + PW'(not_above[i] & ~expiring[i]);
      if (expiring[i]) begin
        drop_pos = AW'(i);
        drop_any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rank_slot.sv
// One position of the sorted list: next-state choice and its register.
module rank_slot
  import rank_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int IDX   = 0,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] ins_pos,
  input  logic [AW-1:0] drop_pos,
  input  logic          drop_any,
  input  logic [DW-1:0] sample,
  input  logic          lo_vld,
  input  logic [AW-1:0] lo_age,
  input  logic [DW-1:0] lo_data,
  input  logic          hi_vld,
  input  logic [AW-1:0] hi_age,
  input  logic [DW-1:0] hi_data,
  output logic          q_vld,
  output logic [AW-1:0] q_age,
  output logic [DW-1:0] q_data
);
  move_t         mv;
  logic          n_vld;
  logic [AW-1:0] n_age;
  logic [DW-1:0] n_data;

  always_comb begin
    if (int'(ins_pos) == IDX) begin
      mv = MV_LOAD;
    end else if (int'(ins_pos) < IDX) begin
      // above the insertion point: take old slot IDX-1 unless the drop is below it
      mv = (drop_any && int'(drop_pos) < IDX) ? MV_KEEP : MV_FROM_BELOW;
    end else begin
      // below the insertion point: close the gap if the drop is at or under IDX
      mv = (drop_any && int'(drop_pos) <= IDX) ? MV_FROM_ABOVE : MV_KEEP;
    end
  end

  always_comb begin
    n_vld  = q_vld;
    n_age  = q_age;
    n_data = q_data;
    unique case (mv)
      MV_KEEP:       begin n_vld = q_vld;  n_age = q_age;  n_data = q_data;  end
      MV_FROM_ABOVE: begin n_vld = hi_vld; n_age = hi_age; n_data = hi_data; end
      MV_FROM_BELOW: begin n_vld = lo_vld; n_age = lo_age; n_data = lo_data; end
      MV_LOAD:       begin n_vld = 1'b1;   n_age = '0;     n_data = sample;  end
      default:       begin n_vld = q_vld;  n_age = q_age;  n_data = q_data;  end
    endcase
    if (mv != MV_LOAD) begin
      n_age = n_vld ? n_age + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld  <= 1'b0;
      q_age  <= '0;
      q_data <= '0;
    end else if (load) begin
      q_vld  <= n_vld;
      q_age  <= n_age;
      q_data <= n_data;
    end
  end
endmodule

// File: rtl/rank_fill.sv
// Counts accepted samples until the window is full.
module rank_fill #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic full
);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEPTH - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (load && !full) begin
      cnt  <= cnt + 1'b1;
      full <= (cnt == CNT_LAST);
    end
  end
endmodule

// File: rtl/rank_select.sv
module rank_select #(
  parameter int DW         = 16,
  parameter int DEPTH      = 32,
  parameter int RANK       = 24,
  parameter bit SIGNED_CMP = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          rank_valid,
  output logic [DW-1:0] rank_out
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]         slot_vld;
  logic [DEPTH-1:0][AW-1:0] slot_age;
  logic [DEPTH-1:0][DW-1:0] slot_data;
  logic [DEPTH-1:0]         not_above;
  logic [DEPTH-1:0]         expiring;
  logic [PW-1:0]            ins_pos;
  logic [AW-1:0]            drop_pos;
  logic                     drop_any;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic          lo_vld, hi_vld;
      logic [AW-1:0] lo_age, hi_age;
      logic [DW-1:0] lo_data, hi_data;

      if (i == 0) begin : g_bottom
        assign lo_vld  = slot_vld[i];
        assign lo_age  = slot_age[i];
        assign lo_data = slot_data[i];
      end else begin : g_lo
        assign lo_vld  = slot_vld[i-1];
        assign lo_age  = slot_age[i-1];
        assign lo_data = slot_data[i-1];
      end

      if (i == DEPTH - 1) begin : g_top
        assign hi_vld  = 1'b0;
        assign hi_age  = '0;
        assign hi_data = '0;
      end else begin : g_hi
        assign hi_vld  = slot_vld[i+1];
        assign hi_age  = slot_age[i+1];
        assign hi_data = slot_data[i+1];
      end

      rank_probe #(.DW(DW), .DEPTH(DEPTH), .SIGNED_CMP(SIGNED_CMP)) u_probe (
        .vld       (slot_vld[i]),
        .age       (slot_age[i]),
        .data      (slot_data[i]),
        .sample    (in_data),
        .not_above (not_above[i]),
        .expiring  (expiring[i])
      );

      rank_slot #(.DW(DW), .DEPTH(DEPTH), .IDX(i)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .load     (in_valid),
        .ins_pos  (ins_pos),
        .drop_pos (drop_pos),
        .drop_any (drop_any),
        .sample   (in_data),
        .lo_vld   (lo_vld),
        .lo_age   (lo_age),
        .lo_data  (lo_data),
        .hi_vld   (hi_vld),
        .hi_age   (hi_age),
        .hi_data  (hi_data),
        .q_vld    (slot_vld[i]),
        .q_age    (slot_age[i]),
        .q_data   (slot_data[i])
      );
    end
  endgenerate

  rank_place #(.DEPTH(DEPTH)) u_place (
    .not_above (not_above),
    .expiring  (expiring),
    .ins_pos   (ins_pos),
    .drop_pos  (drop_pos),
    .drop_any  (drop_any)
  );

  rank_fill #(.DEPTH(DEPTH)) u_fill (
    .clk  (clk),
    .rst  (rst),
    .load (in_valid),
    .full (rank_valid)
  );

  assign rank_out = slot_data[RANK-1];
endmodule

// File: rtl/rank_select_chk.sv
module rank_select_chk #(
  parameter int DW         = 16,
  parameter int DEPTH      = 32,
  parameter bit SIGNED_CMP = 1'b0,
  localparam int AW        = $clog2(DEPTH)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     rank_valid,
  input logic [DEPTH-1:0]         slot_vld,
  input logic [DEPTH-1:0][AW-1:0] slot_age,
  input logic [DEPTH-1:0][DW-1:0] slot_data,
  input logic [DEPTH-1:0]         expiring
);
  logic order_ok, prefix_ok;

  always_comb begin
    order_ok  = 1'b1;
    prefix_ok = 1'b1;
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (slot_vld[i+1] && !slot_vld[i]) prefix_ok = 1'b0;
      if (slot_vld[i+1] && slot_vld[i]) begin
        if (SIGNED_CMP ? ($signed(slot_data[i]) > $signed(slot_data[i+1]))
                       : (slot_data[i] > slot_data[i+1]))
          order_ok = 1'b0;
      end
    end
  end

  a_r1_reset_empties: assert property (@(posedge clk)
    rst |=> (slot_vld == '0) && !rank_valid);

  a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
    order_ok);

  a_r2_contiguous: assert property (@(posedge clk) disable iff (rst)
    prefix_ok);

  a_r4_single_expiry: assert property (@(posedge clk) disable iff (rst)
    $onehot0(expiring));

  a_r5_full_window: assert property (@(posedge clk) disable iff (rst)
    rank_valid |-> (&slot_vld));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(slot_data) && $stable(slot_vld) && $stable(slot_age)
                  && $stable(rank_valid));
endmodule

bind rank_select rank_select_chk #(
  .DW(DW), .DEPTH(DEPTH), .SIGNED_CMP(SIGNED_CMP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .rank_valid (rank_valid),
  .slot_vld   (slot_vld),
  .slot_age   (slot_age),
  .slot_data  (slot_data),
  .expiring   (expiring)
);

// File: tb/sim_rank_select.sv
`timescale 1ns/1ps
module sim_rank_select;
  localparam int DW = 16, DEPTH = 32, RANK = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          uv_u, uv_s;
  logic [DW-1:0] rk_u, rk_s;

  logic [DW-1:0] hist [DEPTH];
  int fill = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  rank_select #(.DW(DW), .DEPTH(DEPTH), .RANK(RANK), .SIGNED_CMP(1'b0)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .rank_valid(uv_u), .rank_out(rk_u));

  rank_select #(.DW(DW), .DEPTH(DEPTH), .RANK(RANK), .SIGNED_CMP(1'b1)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .rank_valid(uv_s), .rank_out(rk_s));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] model_rank(bit sgn);
    int v [DEPTH];
    for (int i = 0; i < DEPTH; i++) v[i] = sgn ? int'($signed(hist[i])) : int'(hist[i]);
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j < DEPTH - 1 - i; j++)
        if (v[j] > v[j+1]) begin
          int t = v[j]; v[j] = v[j+1]; v[j+1] = t;
        end
    return v[RANK-1][DW-1:0];
  endfunction

  // Drives one cycle starting at a falling edge; checks after the next falling edge.
  task automatic step(bit v, logic [DW-1:0] x, string req);
    in_valid = v;
    in_data  = x;
    @(negedge clk);
    if (v) begin
      for (int i = 0; i < DEPTH - 1; i++) hist[i] = hist[i+1];
      hist[DEPTH-1] = x;
      if (fill < DEPTH) fill++;
    end
    chk(req, "valid unsigned", 32'(uv_u), 32'(fill >= DEPTH));
    chk(req, "valid signed", 32'(uv_s), 32'(fill >= DEPTH));
    if (fill >= DEPTH) begin
      chk(req, "rank unsigned", 32'(rk_u), 32'(model_rank(1'b0)));
      chk(req, "rank signed", 32'(rk_s), 32'(model_rank(1'b1)));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    fill = 0;
    chk("R1", "valid after reset u0", 32'(uv_u), 32'd0);
    chk("R1", "valid after reset u1", 32'(uv_s), 32'd0);
  endtask

  // R5 and R3: ascending ramp fill, flag rises on sample 32
  task automatic t_fill_ramp();
    for (int i = 0; i < DEPTH; i++) step(1'b1, DW'(100 + 3 * i), "R5");
    chk("R5", "flag on 32nd", 32'(uv_u), 32'd1);
    chk("R3", "ramp rank", 32'(rk_u), 32'(100 + 3 * (RANK - 1)));
  endtask

  // R2: descending values must still land in order
  task automatic t_descending();
    for (int i = 0; i < 2 * DEPTH; i++) step(1'b1, DW'(5000 - 7 * i), "R2");
  endtask

  // R4: staged drop-out, rank switches to 0 on the RANK-th zero
  task automatic t_dropout();
    for (int i = 0; i < DEPTH; i++) step(1'b1, DW'(1000), "R4");
    for (int k = 1; k <= DEPTH; k++) begin
      step(1'b1, '0, "R4");
      chk("R4", "dropout rank", 32'(rk_u), (k >= RANK) ? 32'd0 : 32'd1000);
    end
  endtask

  // R3: pseudo-random stream
  task automatic t_random(int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1'b1, lfsr, "R3");
    end
  endtask

  // R6: idle cycles hold the output
  task automatic t_gaps();
    for (int i = 0; i < 40; i++) begin
      logic [DW-1:0] prev = rk_u;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 3 == 0) begin
        step(1'b0, lfsr, "R6");
        chk("R6", "idle hold", 32'(rk_u), 32'(prev));
      end else begin
        step(1'b1, lfsr, "R3");
      end
    end
  endtask

  // R7: heavy duplicates
  task automatic t_duplicates();
    for (int i = 0; i < 3 * DEPTH; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1'b1, DW'(40 + 10 * (lfsr % 3)), "R7");
    end
  endtask

  // R8: values straddling the sign bit; u0 and u1 must order them differently
  task automatic t_signed();
    for (int i = 0; i < DEPTH; i++) step(1'b1, (i % 2) ? 16'hFFF0 : 16'h0010, "R8");
    chk("R8", "unsigned rank", 32'(rk_u), 32'h0000FFF0);
    chk("R8", "signed rank", 32'(rk_s), 32'h00000010);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fill_ramp();
    t_descending();
    t_dropout();
    t_random(300);
    t_gaps();
    t_duplicates();
    t_reset();
    t_signed();
    t_reset();
    for (int i = 0; i < DEPTH - 1; i++) step(1'b1, DW'(i), "R5");
    chk("R5", "not yet full", 32'(uv_u), 32'd0);
    step(1'b1, DW'(7), "R5");
    in_valid = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule